// File: doc/BRIEF.md
# Display Command Ring Consumer

This block reads a stream of 32-bit command words from a circular buffer in memory and turns them into register writes for a display pipeline. Software places words in the buffer and then moves a put pointer forward. The block fetches words at its own get pointer and keeps going until the two pointers are equal. Software can then read the get pointer to see how far the block has advanced.

A method header gives a starting method address and a count of data words. The data words that follow it go to consecutive method addresses. Writes that land in the staging window go into a staging register file. A write to the commit method copies the whole staging file into the active state in one step, so a multi-register change reaches the display all at once. A jump word sends the get pointer back to word zero.

A malformed word records the offending method and data, raises an interrupt and halts fetching. Software restarts the block by writing 1 to the status bit.

Top module: `dcr_engine`

## Requirements
- R1: After reset, the put pointer, the get pointer, the error status bit, `err_irq`, `mth_we` and every active register are all zero.
- R2: Fetching stops when the get pointer equals the put pointer. Both pointers read back in bytes, each equal to the word index times 4.
- R3: A header word with bits 31:29 equal to zero carries a data-word count in bits 28:18 and a byte method address in bits 11:2 (bits 1:0 ignored). Data word i of the packet goes to method address plus 4*i.
- R4: A data word that targets the staging window (byte addresses `STG_BASE*4` up to `(STG_BASE+NREG)*4 - 4`) updates only the staging register. The active state does not change.
- R5: A data word sent to method byte address 0x080 copies every staging register into the active state in the cycle it is consumed. Its data value is ignored.
- R6: The word 0x20000000, taken in header position, sets the get pointer to word 0. Fetching continues from there.
- R7: A data word whose method address is neither 0x080 nor inside the staging window is an error. The error method register captures its byte method address, and the error data register captures the word. `err_irq` and the status bit go high, and the remaining words of that packet are dropped.
- R8: A header word with nonzero bits 31:29 other than exactly 0x20000000 is an error. The error method register captures the word itself, and the error data register captures 0.
- R9: While the status bit is set, no memory read is issued. The get pointer stays one word past the offending word, and the active state is unchanged.
- R10: Writing host register 2 with bit 0 set clears the status bit and `err_irq`. Writing it with bit 0 clear has no effect. Fetching then resumes at the word after the offending one, and that word is taken as a header.
- R11: Each accepted staging or commit write shows on the method port as a one-cycle `mth_we` pulse carrying the byte method address and the data word.
- R12: A header with count zero is consumed without any method write.
- R13: Host register map, with registered read data one cycle after `host_rd`: 0 is put (writable; bits 1:0 are dropped), 1 is get (read-only), 2 is status (bit 0), 3 is the error method, and 4 is the error data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 3 | Host register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| mem_rd_en | output | 1 | Buffer read request |
| mem_rd_addr | output | RING_AW | Buffer word address |
| mem_rd_data | input | 32 | Buffer word, one cycle after the request |
| mth_we | output | 1 | Method write pulse |
| mth_addr | output | 12 | Method byte address |
| mth_data | output | 32 | Method data |
| active_state | output | NREG*32 | Active registers, register k at bits k*32 upward |
| err_irq | output | 1 | Error interrupt (status bit) |

## Verification
The bench builds the block with a 64-word ring (`RING_AW`=6), 8 staging registers and the staging window at byte 0x400. The small ring lets a jump back to word zero happen after about forty words. The small staging file allows a commit to be compared against every active register. A method address at 0x200 falls outside both the window and the commit method, so the unmapped-method error can be reached with an ordinary header.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam logic [31:0] JUMP_ZERO   = 32'h2000_0000;
  localparam logic [9:0]  COMMIT_W    = 10'h020;   // byte 0x080
  localparam int          CNT_LSB     = 18;
  localparam int          CNT_W       = 11;

  localparam logic [2:0] HR_PUT  = 3'd0;
  localparam logic [2:0] HR_GET  = 3'd1;
  localparam logic [2:0] HR_STAT = 3'd2;
  localparam logic [2:0] HR_EMTH = 3'd3;
  localparam logic [2:0] HR_EDAT = 3'd4;

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_DATA} fetch_st_t;

  typedef struct packed {
    logic [31:0] mthd;
    logic [31:0] data;
  } err_cap_t;
endpackage

// File: rtl/dcr_host_regs.sv
module dcr_host_regs
  import dcr_pkg::*;
#(
  parameter int RING_AW = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [2:0]         host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  input  logic [RING_AW-1:0] get_ptr,
  input  logic               err_set,
  input  err_cap_t           err_in,
  output logic [RING_AW-1:0] put_ptr,
  output logic               err_flag
);
  err_cap_t err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      put_ptr    <= '0;
      err_flag   <= 1'b0;
      err_q      <= '0;
      host_rdata <= '0;
    end else begin
      if (host_wr && host_addr == HR_PUT)
        put_ptr <= host_wdata[RING_AW+1:2];
      if (err_set) begin
        err_flag <= 1'b1;
        err_q    <= err_in;
      end else if (host_wr && host_addr == HR_STAT && host_wdata[0]) begin
        err_flag <= 1'b0;
      end
      if (host_rd) begin
        case (host_addr)
          HR_PUT:  host_rdata <= 32'({put_ptr, 2'b00});
          HR_GET:  host_rdata <= 32'({get_ptr, 2'b00});
          HR_STAT: host_rdata <= {31'b0, err_flag};
          HR_EMTH: host_rdata <= err_q.mthd;
          HR_EDAT: host_rdata <= err_q.data;
          default: host_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dcr_fetch.sv
module dcr_fetch
  import dcr_pkg::*;
#(
  parameter int          RING_AW  = 10,
  parameter int          NREG     = 16,
  parameter logic [9:0]  STG_BASE = 10'h100,
  localparam int         IDXW     = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RING_AW-1:0] put_ptr,
  input  logic               err_flag,
  output logic               mem_rd_en,
  output logic [RING_AW-1:0] mem_rd_addr,
  input  logic [31:0]        mem_rd_data,
  output logic [RING_AW-1:0] get_ptr,
  output logic               err_set,
  output err_cap_t           err_out,
  output logic               stg_we,
  output logic [IDXW-1:0]    stg_idx,
  output logic [31:0]        stg_data,
  output logic               commit,
  output logic               mth_we,
  output logic [11:0]        mth_addr,
  output logic [31:0]        mth_data
);
  localparam logic [10:0] NREG_L = 11'(NREG);

  fetch_st_t         st;
  logic [CNT_W-1:0]  cnt;
  logic [9:0]        maddr;

  // decode of the word being consumed
  logic       consume, in_hdr, is_jump, hdr_bad, hdr_ok, stg_hit, dat_bad;
  logic [9:0] off;

  always_comb begin
    consume = (st == F_DATA);
    in_hdr  = (cnt == '0);
    off     = maddr - STG_BASE;
    is_jump = consume && in_hdr && (mem_rd_data == JUMP_ZERO);
    hdr_bad = consume && in_hdr && !is_jump && (mem_rd_data[31:29] != 3'b000);
    hdr_ok  = consume && in_hdr && (mem_rd_data[31:29] == 3'b000);
    commit  = consume && !in_hdr && (maddr == COMMIT_W);
    stg_hit = ({1'b0, off} < NREG_L);
    stg_we  = consume && !in_hdr && (maddr != COMMIT_W) && stg_hit;
    dat_bad = consume && !in_hdr && (maddr != COMMIT_W) && !stg_hit;
    stg_idx = off[IDXW-1:0];
    stg_data = mem_rd_data;
    err_set = hdr_bad || dat_bad;
    err_out.mthd = hdr_bad ? mem_rd_data : {20'b0, maddr, 2'b00};
    err_out.data = hdr_bad ? 32'b0 : mem_rd_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= F_IDLE;
      cnt         <= '0;
      maddr       <= '0;
      get_ptr     <= '0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      mth_we      <= 1'b0;
      mth_addr    <= '0;
      mth_data    <= '0;
    end else begin
      mth_we <= 1'b0;
      case (st)
        F_IDLE: begin
          if (!err_flag && get_ptr != put_ptr) begin
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= get_ptr;
            st          <= F_REQ;
          end
        end
        F_REQ: begin
          mem_rd_en <= 1'b0;
          st        <= F_DATA;
        end
        default: begin
          st <= F_IDLE;
          if (is_jump) begin
            get_ptr <= '0;
          end else begin
            get_ptr <= get_ptr + 1'b1;
          end
          if (hdr_ok) begin
            cnt   <= mem_rd_data[CNT_LSB +: CNT_W];
            maddr <= mem_rd_data[11:2];
          end
          if (commit || stg_we) begin
            cnt      <= cnt - 1'b1;
            maddr    <= maddr + 1'b1;
            mth_we   <= 1'b1;
            mth_addr <= {maddr, 2'b00};
            mth_data <= mem_rd_data;
          end
          if (dat_bad) cnt <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/dcr_state_file.sv
module dcr_state_file #(
  parameter int  NREG = 16,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stg_we,
  input  logic [IDXW-1:0]   stg_idx,
  input  logic [31:0]       stg_data,
  input  logic              commit,
  output logic [NREG*32-1:0] active_state
);
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [31:0] staged;
    always_ff @(posedge clk) begin
      if (rst) begin
        staged                 <= '0;
        active_state[k*32 +: 32] <= '0;
      end else begin
        if (stg_we && stg_idx == IDXW'(k)) staged <= stg_data;
        if (commit) active_state[k*32 +: 32] <= staged;
      end
    end
  end
endmodule

// File: rtl/dcr_engine.sv
module dcr_engine
  import dcr_pkg::*;
#(
  parameter int         RING_AW  = 10,
  parameter int         NREG     = 16,
  parameter logic [9:0] STG_BASE = 10'h100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [2:0]         host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic               mem_rd_en,
  output logic [RING_AW-1:0] mem_rd_addr,
  input  logic [31:0]        mem_rd_data,
  output logic               mth_we,
  output logic [11:0]        mth_addr,
  output logic [31:0]        mth_data,
  output logic [NREG*32-1:0] active_state,
  output logic               err_irq
);
  localparam int IDXW = $clog2(NREG);

  logic [RING_AW-1:0] put_ptr, get_ptr;
  logic               err_flag, err_set, stg_we, commit;
  err_cap_t           err_cap;
  logic [IDXW-1:0]    stg_idx;
  logic [31:0]        stg_data;

  dcr_host_regs #(.RING_AW(RING_AW)) u_regs (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .get_ptr(get_ptr), .err_set(err_set), .err_in(err_cap),
    .put_ptr(put_ptr), .err_flag(err_flag)
  );

  dcr_fetch #(.RING_AW(RING_AW), .NREG(NREG), .STG_BASE(STG_BASE)) u_fetch (
    .clk(clk), .rst(rst), .put_ptr(put_ptr), .err_flag(err_flag),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .get_ptr(get_ptr), .err_set(err_set), .err_out(err_cap),
    .stg_we(stg_we), .stg_idx(stg_idx), .stg_data(stg_data), .commit(commit),
    .mth_we(mth_we), .mth_addr(mth_addr), .mth_data(mth_data)
  );

  dcr_state_file #(.NREG(NREG)) u_state (
    .clk(clk), .rst(rst), .stg_we(stg_we), .stg_idx(stg_idx),
    .stg_data(stg_data), .commit(commit), .active_state(active_state)
  );

  assign err_irq = err_flag;
endmodule

// File: rtl/dcr_engine_chk.sv
module dcr_engine_chk #(
  parameter int         RING_AW  = 10,
  parameter int         NREG     = 16,
  parameter logic [9:0] STG_BASE = 10'h100
) (
  input logic               clk,
  input logic               rst,
  input logic               host_wr,
  input logic [2:0]         host_addr,
  input logic [31:0]        host_wdata,
  input logic               mem_rd_en,
  input logic               mth_we,
  input logic [11:0]        mth_addr,
  input logic [NREG*32-1:0] active_state,
  input logic               err_irq
);
  localparam logic [10:0] NREG_L = 11'(NREG);
  logic [9:0] wofs;
  assign wofs = mth_addr[11:2] - STG_BASE;

  // R1
  a_r1_reset_clean: assert property (@(posedge clk)
    rst |=> (!err_irq && !mth_we && active_state == '0));

  // R4 and R5: active state moves only together with a commit write
  a_r4_active_only_on_commit: assert property (@(posedge clk) disable iff (rst)
    !$stable(active_state) |-> (mth_we && mth_addr == 12'h080));

  // R9
  a_r9_no_fetch_in_error: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> !mem_rd_en);

  // R7: error stays until cleared
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_irq && !(host_wr && host_addr == 3'd2 && host_wdata[0])) |=> err_irq);

  // R10
  a_r10_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    (err_irq && host_wr && host_addr == 3'd2 && host_wdata[0]) |=> !err_irq);

  // R11: only mapped methods reach the method port
  a_r11_mapped_only: assert property (@(posedge clk) disable iff (rst)
    mth_we |-> (mth_addr == 12'h080 || {1'b0, wofs} < NREG_L));
endmodule

bind dcr_engine dcr_engine_chk #(.RING_AW(RING_AW), .NREG(NREG), .STG_BASE(STG_BASE)) u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .mem_rd_en(mem_rd_en), .mth_we(mth_we),
  .mth_addr(mth_addr), .active_state(active_state), .err_irq(err_irq)
);

// File: tb/sim_dcr_engine.sv
module sim_dcr_engine;
  localparam int RING_AW = 6;
  localparam int NREG    = 8;
  localparam int RSZ     = 1 << RING_AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic mem_rd_en;
  logic [RING_AW-1:0] mem_rd_addr;
  logic [31:0] mem_rd_data;
  logic mth_we;
  logic [11:0] mth_addr;
  logic [31:0] mth_data;
  logic [NREG*32-1:0] active_state;
  logic err_irq;

  always #2.5 clk = ~clk;

  dcr_engine #(.RING_AW(RING_AW), .NREG(NREG), .STG_BASE(10'h100)) u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mth_we(mth_we), .mth_addr(mth_addr), .mth_data(mth_data),
    .active_state(active_state), .err_irq(err_irq)
  );

  // ring buffer memory, synchronous read
  logic [31:0] ring [RSZ];
  logic [31:0] rd_q = '0;
  always @(posedge clk) if (mem_rd_en) rd_q <= ring[mem_rd_addr];
  assign mem_rd_data = rd_q;

  // method port log
  int mcount = 0;
  logic [11:0] log_a [256];
  logic [31:0] log_d [256];
  always @(negedge clk) if (!rst && mth_we) begin
    log_a[mcount % 256] = mth_addr;
    log_d[mcount % 256] = mth_data;
    mcount++;
  end

  int tests = 0, fails = 0, wp = 0;
  bit done = 0;
  logic [31:0] rv;
  logic [31:0] shadow [NREG];

  // stimulus table: {slot, value}, each followed by a commit
  localparam logic [63:0] VEC [6] = '{
    {32'd0, 32'h1111_0000}, {32'd3, 32'hA5A5_5A5A}, {32'd7, 32'hFFFF_FFFF},
    {32'd1, 32'h0000_0001}, {32'd5, 32'h8000_0000}, {32'd2, 32'h0BAD_F00D}};

  function automatic logic [31:0] hdr(input int n, input int baddr);
    return (32'(n) << 18) | 32'(baddr);
  endfunction
  function automatic logic [31:0] act(input int k);
    return active_state[k*32 +: 32];
  endfunction

  task automatic chk(input string tag, input logic [31:0] actual, input logic [31:0] exp);
    tests++;
    if (actual !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, actual, exp);
    end
  endtask

  task automatic hw(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask
  task automatic hr(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); host_rd = 1; host_addr = a;
    @(negedge clk); host_rd = 0; d = host_rdata;
  endtask
  task automatic push(input logic [31:0] w);
    ring[wp] = w; wp = (wp + 1) % RSZ;
  endtask
  task automatic kick();
    hw(3'd0, 32'(wp * 4));
  endtask
  task automatic wait_idle();
    logic [31:0] g;
    for (int i = 0; i < 500; i++) begin
      hr(3'd1, g);
      if (g == 32'(wp * 4)) break;
    end
    repeat (2) @(negedge clk);
  endtask
  task automatic stg_commit(input int slot, input logic [31:0] v);
    push(hdr(1, 32'h400 + slot * 4)); push(v);
    push(hdr(1, 32'h080)); push(32'hDEAD_0000);
    shadow[slot] = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int m0;
    for (int i = 0; i < RSZ; i++) ring[i] = '0;
    for (int i = 0; i < NREG; i++) shadow[i] = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    hr(3'd0, rv); chk("R1 put", rv, 0);
    hr(3'd1, rv); chk("R1 get", rv, 0);
    hr(3'd2, rv); chk("R1 status", rv, 0);
    chk("R1 irq", 32'(err_irq), 0);
    chk("R1 active", 32'(active_state != '0), 0);

    // table walk: R5 commit, R11 method port
    for (int r = 0; r < 6; r++) begin
      int slot; logic [31:0] v;
      slot = int'(VEC[r][63:32]); v = VEC[r][31:0];
      m0 = mcount;
      stg_commit(slot, v);
      kick(); wait_idle();
      for (int k = 0; k < NREG; k++) chk("R5 active after commit", act(k), shadow[k]);
      chk("R11 write count", 32'(mcount - m0), 2);
      chk("R11 stage addr", 32'(log_a[m0 % 256]), 32'h400 + slot * 4);
      chk("R11 stage data", log_d[m0 % 256], v);
      chk("R11 commit addr", 32'(log_a[(m0 + 1) % 256]), 32'h080);
    end

    // R2 get equals put in bytes; R13 put drops low bits
    hr(3'd1, rv); chk("R2 get bytes", rv, 32'(wp * 4));
    hw(3'd0, 32'(wp * 4) | 32'h3);
    hr(3'd0, rv); chk("R13 put aligned", rv, 32'(wp * 4));

    // R4 staged without commit
    push(hdr(1, 32'h408)); push(32'h0000_1234);
    kick(); wait_idle();
    chk("R4 active held", act(2), shadow[2]);
    push(hdr(1, 32'h081)); push(32'h0);   // low bits of method ignored (R3)
    kick(); wait_idle();
    chk("R4 then commit", act(2), 32'h0000_1234); shadow[2] = 32'h1234;

    // R3 multi-word packet to consecutive methods
    m0 = mcount;
    push(hdr(3, 32'h410)); push(32'hC0DE_0004); push(32'hC0DE_0005); push(32'hC0DE_0006);
    push(hdr(1, 32'h080)); push(32'h0);
    kick(); wait_idle();
    chk("R3 slot4", act(4), 32'hC0DE_0004);
    chk("R3 slot5", act(5), 32'hC0DE_0005);
    chk("R3 slot6", act(6), 32'hC0DE_0006);
    chk("R3 addr+4", 32'(log_a[(m0 + 1) % 256]), 32'h414);
    chk("R3 addr+8", 32'(log_a[(m0 + 2) % 256]), 32'h418);

    // R12 zero-count header
    m0 = mcount;
    push(hdr(0, 32'h400));
    push(hdr(1, 32'h41C)); push(32'h7777_0007);
    push(hdr(1, 32'h080)); push(32'h0);
    kick(); wait_idle();
    chk("R12 writes", 32'(mcount - m0), 2);
    chk("R12 slot7", act(7), 32'h7777_0007);

    // R6 jump to zero
    push(32'h2000_0000);
    wp = 0;
    push(hdr(1, 32'h400)); push(32'h0606_0606);
    push(hdr(1, 32'h080)); push(32'h0);
    kick(); wait_idle();
    chk("R6 after jump", act(0), 32'h0606_0606);
    hr(3'd1, rv); chk("R6 get", rv, 32'(wp * 4));

    // R7 unmapped method, R9 stall, R10 clear
    m0 = wp;
    push(hdr(2, 32'h200)); push(32'h0000_BAD1); push(32'h0000_BAD2);
    push(hdr(1, 32'h404)); push(32'h0000_0077);
    push(hdr(1, 32'h080)); push(32'h0);
    kick(); repeat (40) @(negedge clk);
    chk("R7 irq", 32'(err_irq), 1);
    hr(3'd2, rv); chk("R7 status", rv, 1);
    hr(3'd3, rv); chk("R7 err method", rv, 32'h200);
    hr(3'd4, rv); chk("R7 err data", rv, 32'h0000_BAD1);
    hr(3'd1, rv); chk("R9 get held", rv, 32'((m0 + 2) * 4));
    chk("R9 active held", act(1), shadow[1]);
    hw(3'd2, 32'h0);
    hr(3'd2, rv); chk("R10 write 0 no effect", rv, 1);
    hw(3'd2, 32'h1);
    chk("R10 irq cleared", 32'(err_irq), 0);
    wait_idle();
    chk("R10 resumed", act(1), 32'h0000_0077);
    chk("R10 no new error", 32'(err_irq), 0);

    // R8 bad jump word
    push(32'h2000_0040);
    push(hdr(1, 32'h418)); push(32'h0808_0808);
    push(hdr(1, 32'h080)); push(32'h0);
    kick(); repeat (30) @(negedge clk);
    chk("R8 irq", 32'(err_irq), 1);
    hr(3'd3, rv); chk("R8 err method", rv, 32'h2000_0040);
    hr(3'd4, rv); chk("R8 err data", rv, 32'h0);
    hw(3'd2, 32'h1);
    wait_idle();
    chk("R8 recovered", act(6), 32'h0808_0808);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule